// File: doc/BRIEF.md
# Two-Word-Aware Instruction Issue Sequencer

This block fetches and issues instructions for a small 8-bit core whose program memory holds 16-bit words. It keeps the program counter, reads program memory one word per instruction cycle, and sends exactly one issue slot per cycle to the execute stage. A slot is a real instruction, a forced NOP, or an empty bubble. One instruction cycle is four clocks. The block produces the phase count and a strobe that marks the last clock of each cycle. All fetch and issue state changes on that strobe edge and at no other time.

A parameterised table of masked patterns picks out the first word of each double-word instruction. When such a word is fetched, the block holds it and issues a bubble while it reads the next word. That next word is appended without being decoded, and both words are then issued together as one 32-bit slot. A word whose top nibble is 1111 is the tail word of a double-word instruction. If it is reached on its own, for example as the landing point of a skip, it is issued as a forced NOP.

The execute stage reports a taken conditional or a program-counter change by raising a redirect with a target address. The block then discards the word it had prefetched, including a first word it was about to complete. It loads the target and fills the slot with a forced NOP. As a result, a taken single-word instruction costs two cycles and a taken double-word branch costs three.

Top module: `isq_issue_seq`

## Requirements
- R1: `cyc_phase` counts 0,1,2,3 and wraps, one step per clock. `cyc_strobe` is high exactly when the phase is 3, once every four clocks. The issue outputs and `fetch_pc` change only at the edge that ends a strobe clock.
- R2: Reset is asynchronous, and its release passes through two synchroniser flops. After release, `fetch_pc` is 0 and `issue_valid` is 0 until the sixth rising edge, which ends the first full instruction cycle. The first slot carries the word at address 0.
- R3: A word that is neither a tail word nor a double-word first word is issued in one cycle. It gives `issue_valid`=1, `issue_nop`=0, `issue_dword`=0 and `issue_word`={word,16'h0000}, and `fetch_pc` steps by one.
- R4: A word is a double-word first word when (word & MASK)==MATCH for any table entry. The defaults are F000/C000, FE00/EC00 and FF00/EF00. Such a word gives a bubble slot with `issue_valid`=0 and `need_second`=1. The next slot has `issue_dword`=1 and `issue_word`={first,second}, whatever the second word contains. Over the two slots, `fetch_pc` advances by two.
- R5: A word with bits [15:12]=4'b1111 that is fetched on its own is issued as `issue_valid`=1 and `issue_nop`=1 with `issue_word`={word,16'h0000}. It never starts a double-word gather, and `fetch_pc` steps by one.
- R6: `br_taken` is sampled at a strobe edge. It is honoured when the slot then on the outputs is a real instruction (`issue_valid`=1, `issue_nop`=0). The next slot is then a forced NOP with word 0, `fetch_pc` becomes `br_target`, and the prefetched word is discarded, even if it was a double-word first word.
- R7: `br_taken` at a strobe edge whose current slot is a bubble or a forced NOP has no effect on the slot or on `fetch_pc`.
- R8: A taken single-word instruction occupies two slots (itself and one flush). A taken double-word branch occupies three (bubble, issue, flush). Two redirects may follow each other with only the one flush slot between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | output | PC_W | Program-memory address being fetched |
| pm_data | input | IW | Program-memory word at `fetch_pc` |
| br_taken | input | 1 | Execute stage reports a taken test or PC change |
| br_target | input | PC_W | New program-counter value for a redirect |
| cyc_phase | output | PH_W | Phase within the instruction cycle |
| cyc_strobe | output | 1 | High on the last clock of each instruction cycle |
| issue_word | output | 2*IW | Issued instruction, first word in the upper half |
| issue_valid | output | 1 | Slot holds an instruction or forced NOP |
| issue_nop | output | 1 | Slot is a forced NOP |
| issue_dword | output | 1 | Slot holds a complete double-word instruction |
| need_second | output | 1 | A first word is held and the next word will be appended |

## Verification
The checker watches four things on every clock. It checks the strobe spacing and that the outputs stay stable between strobes. It checks that a bubble is always followed by a complete double-word slot. It checks that a lone tail word becomes a forced NOP, and that an honoured redirect yields a flush slot at the target address. Some properties are only visible over whole programs, so the bench scenarios cover them. These are the exact cycle cost of taken skips and branches, a skip landing on the tail of a double-word instruction, back-to-back redirects, and a discarded pending first word. The bench also shows that redirects during bubbles and forced NOPs are ignored.

// File: rtl/isq_pkg.sv
package isq_pkg;
  // Upper-nibble value carried by the tail word of a double-word instruction
  localparam logic [3:0] TAIL_TAG = 4'hF;
endpackage

// File: rtl/isq_reset_sync.sv
module isq_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/isq_phase_gen.sv
module isq_phase_gen #(
  parameter int CYC_LEN = 4,
  parameter int PH_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            strobe
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    if (phase_q == PH_LAST) phase_d = '0;
    else                    phase_d = phase_q + PH_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase  = phase_q;
  assign strobe = (phase_q == PH_LAST);
endmodule

// File: rtl/isq_dword_match.sv
module isq_dword_match #(
  parameter int                     IW     = 16,
  parameter int                     NUM_DW = 3,
  parameter logic [NUM_DW*IW-1:0]   MATCH  = '0,
  parameter logic [NUM_DW*IW-1:0]   MASK   = '0
) (
  input  logic [IW-1:0] word,
  output logic          is_first,
  output logic          is_tail
);
  logic [NUM_DW-1:0] hit;

  for (genvar g = 0; g < NUM_DW; g++) begin : g_class
    assign hit[g] = ((word & MASK[g*IW +: IW]) == MATCH[g*IW +: IW]);
  end

  assign is_tail  = (word[IW-1 -: 4] == isq_pkg::TAIL_TAG);
  assign is_first = (|hit) && !is_tail;
endmodule

// File: rtl/isq_issue_seq.sv
module isq_issue_seq #(
  parameter int                   PC_W     = 8,
  parameter int                   IW       = 16,
  parameter int                   NUM_DW   = 3,
  parameter int                   CYC_LEN  = 4,
  parameter logic [NUM_DW*IW-1:0] DW_MATCH = {16'hEF00, 16'hEC00, 16'hC000},
  parameter logic [NUM_DW*IW-1:0] DW_MASK  = {16'hFF00, 16'hFE00, 16'hF000},
  localparam int                  PH_W     = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1,
  localparam int                  XW       = 2 * IW
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] fetch_pc,
  input  logic [IW-1:0]   pm_data,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [PH_W-1:0] cyc_phase,
  output logic            cyc_strobe,
  output logic [XW-1:0]   issue_word,
  output logic            issue_valid,
  output logic            issue_nop,
  output logic            issue_dword,
  output logic            need_second
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic rst_s_n;
  logic strobe;
  logic is_first;
  logic is_tail;

  logic [PC_W-1:0] pc_q,    pc_d;
  logic [IW-1:0]   held_q,  held_d;
  logic            gath_q,  gath_d;
  logic [XW-1:0]   word_q,  word_d;
  logic            vld_q,   vld_d;
  logic            nop_q,   nop_d;
  logic            dw_q,    dw_d;
  logic            redirect_ok;

  isq_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  isq_phase_gen #(
    .CYC_LEN (CYC_LEN),
    .PH_W    (PH_W)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .phase  (cyc_phase),
    .strobe (strobe)
  );

  isq_dword_match #(
    .IW     (IW),
    .NUM_DW (NUM_DW),
    .MATCH  (DW_MATCH),
    .MASK   (DW_MASK)
  ) u_match (
    .word     (pm_data),
    .is_first (is_first),
    .is_tail  (is_tail)
  );

  // A redirect belongs to the real instruction currently on the outputs
  assign redirect_ok = br_taken && vld_q && !nop_q;

  always_comb begin
    pc_d   = pc_q;
    held_d = held_q;
    gath_d = gath_q;
    word_d = word_q;
    vld_d  = vld_q;
    nop_d  = nop_q;
    dw_d   = dw_q;
    if (redirect_ok) begin
      pc_d   = br_target;
      gath_d = 1'b0;
      word_d = '0;
      vld_d  = 1'b1;
      nop_d  = 1'b1;
      dw_d   = 1'b0;
    end else if (gath_q) begin
      pc_d   = pc_q + PC_ONE;
      gath_d = 1'b0;
      word_d = {held_q, pm_data};
      vld_d  = 1'b1;
      nop_d  = 1'b0;
      dw_d   = 1'b1;
    end else if (is_tail) begin
      pc_d   = pc_q + PC_ONE;
      word_d = {pm_data, {IW{1'b0}}};
      vld_d  = 1'b1;
      nop_d  = 1'b1;
      dw_d   = 1'b0;
    end else if (is_first) begin
      pc_d   = pc_q + PC_ONE;
      held_d = pm_data;
      gath_d = 1'b1;
      word_d = '0;
      vld_d  = 1'b0;
      nop_d  = 1'b0;
      dw_d   = 1'b0;
    end else begin
      pc_d   = pc_q + PC_ONE;
      word_d = {pm_data, {IW{1'b0}}};
      vld_d  = 1'b1;
      nop_d  = 1'b0;
      dw_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pc_q   <= '0;
      held_q <= '0;
      gath_q <= 1'b0;
      word_q <= '0;
      vld_q  <= 1'b0;
      nop_q  <= 1'b0;
      dw_q   <= 1'b0;
    end else if (strobe) begin
      pc_q   <= pc_d;
      held_q <= held_d;
      gath_q <= gath_d;
      word_q <= word_d;
      vld_q  <= vld_d;
      nop_q  <= nop_d;
      dw_q   <= dw_d;
    end
  end

  assign fetch_pc    = pc_q;
  assign cyc_strobe  = strobe;
  assign issue_word  = word_q;
  assign issue_valid = vld_q;
  assign issue_nop   = nop_q;
  assign issue_dword = dw_q;
  assign need_second = gath_q;
endmodule

// File: rtl/isq_issue_seq_chk.sv
module isq_issue_seq_chk #(
  parameter int PC_W = 8,
  parameter int IW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic [IW-1:0]   pm_data,
  input logic            br_taken,
  input logic [PC_W-1:0] br_target,
  input logic            cyc_strobe,
  input logic            issue_valid,
  input logic            issue_nop,
  input logic            issue_dword,
  input logic            need_second
);
  logic real_slot;
  assign real_slot = issue_valid && !issue_nop;

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe |=> !cyc_strobe); // R1

  AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> $stable(fetch_pc) && $stable(issue_valid) && $stable(issue_nop)); // R1

  AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    need_second |-> !issue_valid); // R4

  AST_GATHER_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && need_second |=> issue_valid && issue_dword && !issue_nop && !need_second); // R4

  AST_LONE_TAIL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && !need_second && !(br_taken && real_slot) && (pm_data[IW-1 -: 4] == 4'hF)
    |=> issue_valid && issue_nop && !need_second); // R5

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && br_taken && real_slot
    |=> issue_valid && issue_nop && !issue_dword && !need_second && (fetch_pc == $past(br_target))); // R6
endmodule

bind isq_issue_seq isq_issue_seq_chk #(.PC_W(PC_W), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_pc    (fetch_pc),
  .pm_data     (pm_data),
  .br_taken    (br_taken),
  .br_target   (br_target),
  .cyc_strobe  (cyc_strobe),
  .issue_valid (issue_valid),
  .issue_nop   (issue_nop),
  .issue_dword (issue_dword),
  .need_second (need_second)
);

// File: tb/isq_issue_seq_tb.sv
module isq_issue_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 80;

  logic        clk;
  logic        rst_n;
  logic [7:0]  fetch_pc;
  logic [15:0] pm_data;
  logic        br_taken;
  logic [7:0]  br_target;
  logic [1:0]  cyc_phase;
  logic        cyc_strobe;
  logic [31:0] issue_word;
  logic        issue_valid, issue_nop, issue_dword, need_second;

  logic [15:0] mem [256];
  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          v, n, d, ns;
    logic [31:0] word;
    logic [7:0]  pc;
    bit          redir;
    logic [7:0]  tgt;
    string       tag;
  } slot_t;

  slot_t q[$];
  int    ipc;

  isq_issue_seq u_dut (
    .clk (clk), .rst_n (rst_n), .fetch_pc (fetch_pc), .pm_data (pm_data),
    .br_taken (br_taken), .br_target (br_target), .cyc_phase (cyc_phase),
    .cyc_strobe (cyc_strobe), .issue_word (issue_word), .issue_valid (issue_valid),
    .issue_nop (issue_nop), .issue_dword (issue_dword), .need_second (need_second)
  );

  assign pm_data = mem[fetch_pc];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_first_word(input logic [15:0] w);
    if (w[15:12] == 4'hF) return 1'b0;
    return ((w & 16'hF000) == 16'hC000) || ((w & 16'hFE00) == 16'hEC00) ||
           ((w & 16'hFF00) == 16'hEF00);
  endfunction

  function automatic slot_t mk(bit v, bit n, bit d, bit ns, logic [31:0] w,
                               int pc, bit r, int t, string tag);
    slot_t s;
    s.v = v; s.n = n; s.d = d; s.ns = ns; s.word = w; s.pc = pc[7:0];
    s.redir = r; s.tgt = t[7:0]; s.tag = tag;
    return s;
  endfunction

  // Instruction-level interpreter: emits the slots one instruction costs.
  // Bench encoding: Axxx jumps to xx, Bxxx skips one word, EFxx+Fxtt jumps to tt.
  task automatic gen_instr();
    logic [15:0] w, w2;
    int t;
    w = mem[ipc[7:0]];
    if (w[15:12] == 4'hF) begin
      q.push_back(mk(1, 1, 0, 0, {w, 16'h0}, ipc + 1, 0, 0, "R5"));
      ipc = (ipc + 1) % 256;
    end else if (is_first_word(w)) begin
      w2 = mem[(ipc + 1) % 256];
      q.push_back(mk(0, 0, 0, 1, 32'h0, ipc + 1, 0, 0, "R4"));
      if (w[15:8] == 8'hEF) begin
        t = int'(w2[7:0]);
        q.push_back(mk(1, 0, 1, 0, {w, w2}, ipc + 2, 1, t, "R4"));
        q.push_back(mk(1, 1, 0, 0, 32'h0, t, 0, 0, "R8"));
        ipc = t;
      end else begin
        q.push_back(mk(1, 0, 1, 0, {w, w2}, ipc + 2, 0, 0, "R4"));
        ipc = (ipc + 2) % 256;
      end
    end else if (w[15:12] == 4'hA || w[15:12] == 4'hB) begin
      t = (w[15:12] == 4'hA) ? int'(w[7:0]) : (ipc + 2) % 256;
      q.push_back(mk(1, 0, 0, 0, {w, 16'h0}, ipc + 1, 1, t, "R3"));
      q.push_back(mk(1, 1, 0, 0, 32'h0, t, 0, 0, "R6"));
      ipc = t;
    end else begin
      q.push_back(mk(1, 0, 0, 0, {w, 16'h0}, ipc + 1, 0, 0, "R3"));
      ipc = (ipc + 1) % 256;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    slot_t s;
    int    exp_ph;
    bit    prev_strobe;
    bit    spur_tgl;
    bit    spur_now;
    int    done;
    string tag;

    for (int i = 0; i < 256; i++) mem[i] = 16'h0100 + 16'(i);
    mem[8'h00] = 16'h1234;                      // plain
    mem[8'h01] = 16'hC012; mem[8'h02] = 16'hF345; // double-word move
    mem[8'h03] = 16'hB000;                      // skip over next word
    mem[8'h04] = 16'hC0AA; mem[8'h05] = 16'hF0BB; // skipped double-word
    mem[8'h06] = 16'hF777;                      // lone tail word
    mem[8'h07] = 16'hEF00; mem[8'h08] = 16'hF010; // double-word jump to 10
    mem[8'h09] = 16'h5555;
    mem[8'h10] = 16'hA020;                      // jump, prefetch is a first word
    mem[8'h11] = 16'hC000; mem[8'h12] = 16'hF000;
    mem[8'h20] = 16'hA030;                      // back-to-back redirect
    mem[8'h30] = 16'hEC01; mem[8'h31] = 16'hF002;
    mem[8'h32] = 16'h2222;
    mem[8'h33] = 16'hA000;                      // loop to 0

    ipc = 0;
    rst_n = 1'b0; br_taken = 1'b0; br_target = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset release: two sync clocks, then phase 1,2,3
    for (int e = 1; e <= 5; e++) begin
      @(negedge clk);
      exp_ph = (e <= 2) ? 0 : e - 2;
      chk(issue_valid == 1'b0, "R2", "valid before first cycle", 32'(issue_valid), 32'd0);
      chk(fetch_pc == 8'h00, "R2", "pc after reset", 32'(fetch_pc), 32'd0);
      chk(cyc_phase == 2'(exp_ph), "R1", "phase after reset", 32'(cyc_phase), 32'(exp_ph));
      chk(cyc_strobe == (exp_ph == 3), "R1", "strobe after reset", 32'(cyc_strobe), 32'(exp_ph == 3));
    end

    exp_ph = 3; prev_strobe = 1'b1; spur_tgl = 1'b0; spur_now = 1'b0; done = 0;
    while (done < SLOTS) begin
      @(negedge clk);
      exp_ph = (exp_ph + 1) % 4;
      chk(cyc_phase == 2'(exp_ph), "R1", "phase", 32'(cyc_phase), 32'(exp_ph));
      chk(cyc_strobe == (exp_ph == 3), "R1", "strobe", 32'(cyc_strobe), 32'(exp_ph == 3));
      if (prev_strobe) begin
        if (q.size() == 0) gen_instr();
        s = q.pop_front();
        tag = spur_now ? "R7" : s.tag;
        if (done == 0) tag = "R2";
        chk(issue_valid == s.v, tag, "issue_valid", 32'(issue_valid), 32'(s.v));
        chk(issue_nop == s.n, tag, "issue_nop", 32'(issue_nop), 32'(s.n));
        chk(issue_dword == s.d, tag, "issue_dword", 32'(issue_dword), 32'(s.d));
        chk(need_second == s.ns, tag, "need_second", 32'(need_second), 32'(s.ns));
        chk(fetch_pc == s.pc, (s.n && !s.v) ? tag : (s.n ? "R8" : tag), "fetch_pc",
            32'(fetch_pc), 32'(s.pc));
        if (s.v)
          chk(issue_word == s.word, tag, "issue_word", issue_word, s.word);
        spur_now = 1'b0;
        if (s.redir) begin
          br_taken = 1'b1; br_target = s.tgt;
        end else if (!s.v || s.n) begin
          spur_tgl = !spur_tgl;
          br_taken = spur_tgl; br_target = 8'hEE;   // must be ignored (R7)
          spur_now = spur_tgl;
        end else begin
          br_taken = 1'b0; br_target = 8'h00;
        end
        done++;
      end else if (exp_ph == 1) begin
        // Mid-cycle: outputs must not have moved since the strobe edge
        chk(issue_valid == s.v && fetch_pc == s.pc, "R1", "hold between strobes",
            {24'h0, fetch_pc}, {24'h0, s.pc});
      end
      prev_strobe = cyc_strobe;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule